// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block walks one group of hashed page table entries held in memory and decides whether any of them translates the current access. The caller supplies the byte offset of the group (already derived from a hash elsewhere), a compare tag, a protection key, the kind of access (read, write or instruction fetch) and a flag that says whether the group was reached through the primary or the secondary hash. The engine fetches the entries one doubleword at a time through a single 64-bit memory port with a valid/ready request and a read response strobe.

Each entry is 16 bytes: a first doubleword that identifies the page and a second doubleword that holds the real page number, storage attributes and protection code. The search stops at the first matching entry whose protection allows the access. A match that denies the access is remembered, and the scan moves on. Every match after the first must agree with the first on the translation bits, or the search ends with an inconsistency. When a usable match is found, the referenced and changed flags are brought up to date, and the second doubleword is written back only if one of them changed. A one-cycle done strobe reports the verdict, the entry index and the updated second doubleword.

Top module: `pteg_search`

## Requirements
- R1: Entry i of a group has its first doubleword at group offset 16*i and its second at 16*i+8. Entries are scanned in order 0 to 7, and the second doubleword is fetched only for an entry that passes R2 and R3.
- R2: An entry is a candidate only when bit 0 of its first doubleword is 1 (valid) and bit 1 equals the secondary-hash flag `sec_i`.
- R3: A candidate matches when bits [63:7] of its first doubleword equal bits [63:7] of `tag_i`. Bits [6:0] of both are ignored.
- R4: The protection code is {bit 63, bits [1:0]} of the second doubleword. A code with bit 2 set allows nothing. With key 0, codes 0 to 2 allow read and write and code 3 allows read only. With key 1, code 0 allows nothing, codes 1 and 3 allow read only and code 2 allows read and write. `acc_i` is 0 for read, 1 for write, 2 for fetch (3 acts as read). A fetch needs read permission.
- R5: A fetch is denied when bit 2 or bit 3 of the second doubleword is set.
- R6: A match that allows the access ends the scan at once with result 0 (granted) and that entry's index in `idx_o`. Later entries are not read.
- R7: A match that denies the access is recorded and the scan continues. If no grant follows, the result is 1 (violation) with the index of the last violating match.
- R8: When a match is already recorded, a later match whose second doubleword differs in bits [63:12] or [6:0] ends the search with result 3 (inconsistent). There is no write-back, and `pte1_o` is 0. Bits [11:7] take no part in this comparison.
- R9: For a granted or violating result, bit 8 (referenced) of the returned second doubleword is set, and bit 7 (changed) is set on a granted write. If that changes the value, exactly one write of the new value goes to offset 16*idx+8. Otherwise nothing is written.
- R10: With no match, the result is 2 (no match), `pte1_o` is 0 and nothing is written.
- R11: A memory request holds its address, write enable and data stable until `mem_ready_i` is high. Read data is taken on `mem_rvalid_i`.
- R12: `done_o` is high for exactly one cycle per accepted search. `start_i` has no effect while a search is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (taken when idle) |
| base_i | input | ADDR_W | Byte offset of the group |
| tag_i | input | 64 | Compare tag, bits [63:7] used |
| key_i | input | 1 | Protection key |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| sec_i | input | 1 | Secondary-hash flag |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | One-cycle completion strobe |
| res_o | output | 2 | 0 granted, 1 violation, 2 no match, 3 inconsistent |
| idx_o | output | IDX_W | Index of the reported entry |
| pte1_o | output | 64 | Updated second doubleword, or 0 |

## Verification
On every cycle, the assertions check that a request is held until it is accepted, that a write only ever targets the second doubleword of an entry, that the done strobe lasts one cycle, and the flag and zeroing rules of every reported result. The bench scenarios are what show the access decision table, the no-execute rule, the order of the scan with its early stop, the choice of the last violating match, the inconsistency cut-off, whether a write-back happens at all, and that a start during a busy search is ignored.

// File: rtl/pteg_pkg.sv
package pteg_pkg;

  localparam int DW         = 64;
  localparam int TAG_LSB    = 7;
  localparam int PAGE_SHIFT = 12;
  localparam int REF_BIT    = 8;
  localparam int CHG_BIT    = 7;

  // bits that every match of one search must agree on
  localparam logic [DW-1:0] AGREE_MASK =
      ~((64'h1 << PAGE_SHIFT) - 64'h1) | 64'h7F;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam logic [1:0] RES_GRANT  = 2'd0;
  localparam logic [1:0] RES_PROT   = 2'd1;
  localparam logic [1:0] RES_MISS   = 2'd2;
  localparam logic [1:0] RES_INCONS = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RQ0, ST_WT0, ST_RQ1, ST_WT1, ST_UPD, ST_WR, ST_FIN
  } walk_st_t;

  // returns {read_ok, write_ok}
  function automatic logic [1:0] perm_of(input logic key, input logic [2:0] code);
    logic [1:0] p;
    if (code[2]) begin
      p = 2'b00;
    end else if (!key) begin
      p = (code[1:0] == 2'd3) ? 2'b10 : 2'b11;
    end else begin
      case (code[1:0])
        2'd0:    p = 2'b00;
        2'd2:    p = 2'b11;
        default: p = 2'b10;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/pteg_cand.sv
module pteg_cand
  import pteg_pkg::*;
(
  input  logic [DW-1:0] pte0,
  input  logic [DW-1:0] tag,
  input  logic          sec,
  output logic          hit
);
  logic valid_bit, hid_ok, tag_ok;
  logic unused_cand;

  assign valid_bit   = pte0[0];
  assign hid_ok      = (pte0[1] == sec);
  assign tag_ok      = (pte0[DW-1:TAG_LSB] == tag[DW-1:TAG_LSB]);
  assign hit         = valid_bit & hid_ok & tag_ok;
  assign unused_cand = ^{pte0[TAG_LSB-1:2], tag[TAG_LSB-1:0]};
endmodule

// File: rtl/pteg_access.sv
module pteg_access
  import pteg_pkg::*;
(
  input  logic [DW-1:0] pte1,
  input  logic          key,
  input  logic [1:0]    acc,
  output logic          allow
);
  logic [2:0] code;
  logic [1:0] perm;
  logic       no_exec;
  logic       unused_acc;

  assign code       = {pte1[DW-1], pte1[1:0]};
  assign perm       = perm_of(key, code);
  assign no_exec    = pte1[2] | pte1[3];
  assign unused_acc = ^pte1[DW-2:4];

  always_comb begin
    case (acc)
      ACC_WR:  allow = perm[0];
      ACC_FX:  allow = perm[1] & ~no_exec;
      default: allow = perm[1];
    endcase
  end
endmodule

// File: rtl/pteg_rc.sv
module pteg_rc
  import pteg_pkg::*;
(
  input  logic [DW-1:0] pte1,
  input  logic          granted,
  input  logic          is_wr,
  output logic [DW-1:0] pte1_new,
  output logic          changed
);
  always_comb begin
    pte1_new          = pte1;
    pte1_new[REF_BIT] = 1'b1;
    if (granted && is_wr) pte1_new[CHG_BIT] = 1'b1;
  end
  assign changed = (pte1_new != pte1);
endmodule

// File: rtl/pteg_search.sv
module pteg_search
  import pteg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [63:0]       tag_i,
  input  logic              key_i,
  input  logic [1:0]        acc_i,
  input  logic              sec_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        res_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [63:0]       pte1_o
);
  localparam int ENT_SH = 4;
  localparam logic [ADDR_W-1:0] HALF_OFF = ADDR_W'(8);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(N_ENT - 1);

  walk_st_t          st;
  logic [IDX_W-1:0]  idx_q, ridx_q;
  logic [ADDR_W-1:0] base_q;
  logic [DW-1:0]     tag_q, rec_q;
  logic              key_q, sec_q;
  logic [1:0]        acc_q;
  logic              found_q, grant_q, incons_q;

  logic              cand_hit, acc_ok, rc_chg, agree_bad, at_last;
  logic [DW-1:0]     rc_new;
  logic [ADDR_W-1:0] scan_addr, wb_addr;

  pteg_cand u_cand (
    .pte0 (mem_rdata_i),
    .tag  (tag_q),
    .sec  (sec_q),
    .hit  (cand_hit)
  );

  pteg_access u_access (
    .pte1  (mem_rdata_i),
    .key   (key_q),
    .acc   (acc_q),
    .allow (acc_ok)
  );

  pteg_rc u_rc (
    .pte1     (rec_q),
    .granted  (grant_q),
    .is_wr    (acc_q == ACC_WR),
    .pte1_new (rc_new),
    .changed  (rc_chg)
  );

  assign agree_bad = found_q && (((rec_q ^ mem_rdata_i) & AGREE_MASK) != '0);
  assign at_last   = (idx_q == LAST_IDX);
  assign scan_addr = base_q + (ADDR_W'(idx_q) << ENT_SH);
  assign wb_addr   = base_q + (ADDR_W'(ridx_q) << ENT_SH) + HALF_OFF;

  always_comb begin
    mem_req_o   = (st == ST_RQ0) || (st == ST_RQ1) || (st == ST_WR);
    mem_we_o    = (st == ST_WR);
    mem_wdata_o = rec_q;
    case (st)
      ST_RQ1:  mem_addr_o = scan_addr + HALF_OFF;
      ST_WR:   mem_addr_o = wb_addr;
      default: mem_addr_o = scan_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      idx_q    <= '0;
      ridx_q   <= '0;
      base_q   <= '0;
      tag_q    <= '0;
      rec_q    <= '0;
      key_q    <= 1'b0;
      sec_q    <= 1'b0;
      acc_q    <= ACC_RD;
      found_q  <= 1'b0;
      grant_q  <= 1'b0;
      incons_q <= 1'b0;
      done_o   <= 1'b0;
      res_o    <= RES_MISS;
      idx_o    <= '0;
      pte1_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            base_q   <= base_i;
            tag_q    <= tag_i;
            key_q    <= key_i;
            acc_q    <= acc_i;
            sec_q    <= sec_i;
            idx_q    <= '0;
            ridx_q   <= '0;
            rec_q    <= '0;
            found_q  <= 1'b0;
            grant_q  <= 1'b0;
            incons_q <= 1'b0;
            st       <= ST_RQ0;
          end
        end
        ST_RQ0: if (mem_ready_i) st <= ST_WT0;
        ST_WT0: begin
          if (mem_rvalid_i) begin
            if (cand_hit) begin
              st <= ST_RQ1;
            end else if (at_last) begin
              st <= found_q ? ST_UPD : ST_FIN;
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= ST_RQ0;
            end
          end
        end
        ST_RQ1: if (mem_ready_i) st <= ST_WT1;
        ST_WT1: begin
          if (mem_rvalid_i) begin
            if (agree_bad) begin
              incons_q <= 1'b1;
              st       <= ST_FIN;
            end else begin
              rec_q   <= mem_rdata_i;
              ridx_q  <= idx_q;
              found_q <= 1'b1;
              if (acc_ok) begin
                grant_q <= 1'b1;
                st      <= ST_UPD;
              end else if (at_last) begin
                st <= ST_UPD;
              end else begin
                idx_q <= idx_q + 1'b1;
                st    <= ST_RQ0;
              end
            end
          end
        end
        ST_UPD: begin
          rec_q <= rc_new;
          st    <= rc_chg ? ST_WR : ST_FIN;
        end
        ST_WR: if (mem_ready_i) st <= ST_FIN;
        ST_FIN: begin
          done_o <= 1'b1;
          idx_o  <= ridx_q;
          pte1_o <= (found_q && !incons_q) ? rec_q : '0;
          if (incons_q)      res_o <= RES_INCONS;
          else if (!found_q) res_o <= RES_MISS;
          else if (grant_q)  res_o <= RES_GRANT;
          else               res_o <= RES_PROT;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: a pending request keeps its fields until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R12: completion strobe lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: write-back only lands on a second doubleword
  p_wb_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[3:0] == 4'h8));

  // R9: a reported match always carries the referenced flag
  p_ref_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && (res_o == RES_GRANT || res_o == RES_PROT)) |-> pte1_o[REF_BIT]);

  // R9: a granted write carries the changed flag
  p_chg_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && res_o == RES_GRANT && acc_q == ACC_WR) |-> pte1_o[CHG_BIT]);

  // R8 / R10: no usable match returns a zero doubleword
  p_zero_miss_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && (res_o == RES_MISS || res_o == RES_INCONS)) |-> (pte1_o == '0));

endmodule

// File: tb/test_pteg_search.sv
module test_pteg_search;
  localparam int ADDR_W = 32;
  localparam logic [63:0] TAGA = 64'h0123_4567_89AB_CD80;
  localparam logic [63:0] AMASK = 64'hFFFF_FFFF_FFFF_F07F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0;
  logic [63:0] tag_i = '0;
  logic key_i = 1'b0;
  logic [1:0] acc_i = 2'd0;
  logic sec_i = 1'b0;
  logic mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic mem_ready_i = 1'b0;
  logic mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic done_o;
  logic [1:0] res_o;
  logic [2:0] idx_o;
  logic [63:0] pte1_o;

  always #5 clk = ~clk;

  pteg_search #(.ADDR_W(ADDR_W), .N_ENT(8)) i_pteg_search (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .tag_i(tag_i),
    .key_i(key_i), .acc_i(acc_i), .sec_i(sec_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .res_o(res_o), .idx_o(idx_o), .pte1_o(pte1_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int wcnt = 0;
  logic [31:0] lw_addr = '0;
  logic [63:0] lw_data = '0;
  logic [63:0] mem [0:63];
  int rdy_cnt = 0;
  logic s1_v = 1'b0;
  logic [63:0] s1_d = '0;

  typedef struct {
    logic [1:0]  res;
    logic [2:0]  idx;
    logic [63:0] pte1;
    int          nwr;
    logic [31:0] waddr;
    int          wbase;
    string       tagname;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // memory with a stalling request side and a two-cycle read response
  always @(posedge clk) begin
    mem_rvalid_i <= s1_v;
    mem_rdata_i  <= s1_d;
    mem_ready_i  <= (rdy_cnt % 3) != 1;
    rdy_cnt = rdy_cnt + 1;
    s1_v = 1'b0;
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        mem[mem_addr_o[8:3]] = mem_wdata_o;
        wcnt = wcnt + 1;
        lw_addr = mem_addr_o;
        lw_data = mem_wdata_o;
      end else begin
        s1_v = 1'b1;
        s1_d = mem[mem_addr_o[8:3]];
      end
    end
  end

  function automatic logic [63:0] mk0(input logic [63:0] t, input bit h, input bit v);
    return {t[63:7], 5'b0, h, v};
  endfunction

  function automatic logic [63:0] mk1(input logic [2:0] pp, input bit nx, input bit g,
                                      input logic [31:0] rpn, input bit r, input bit c);
    return {pp[2], 19'b0, rpn, 3'b0, r, c, 3'b0, g, nx, pp[1:0]};
  endfunction

  task automatic clear_grp(input int base);
    for (int i = 0; i < 16; i++) mem[(base >> 3) + i] = '0;
  endtask

  task automatic put(input int base, input int e, input logic [63:0] p0, input logic [63:0] p1);
    mem[(base >> 3) + 2*e]     = p0;
    mem[(base >> 3) + 2*e + 1] = p1;
  endtask

  // expected outcome taken from the requirements
  function automatic exp_t predict(input int base, input logic [63:0] t, input bit key,
                                   input logic [1:0] acc, input bit sec);
    exp_t e;
    bit found = 0, granted = 0, incons = 0;
    logic [63:0] rec = '0, nv;
    logic [2:0] ridx = '0;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] p0, p1;
      bit rd, wr, ok;
      logic [2:0] pp;
      p0 = mem[(base >> 3) + 2*i];
      p1 = mem[(base >> 3) + 2*i + 1];
      if (!(p0[0] && p0[1] == sec && p0[63:7] == t[63:7])) continue;
      if (found && ((rec & AMASK) != (p1 & AMASK))) begin incons = 1; break; end
      rec = p1; ridx = 3'(i); found = 1;
      pp = {p1[63], p1[1:0]};
      rd = 0; wr = 0;
      if (!pp[2]) begin
        if (key == 0) begin rd = 1; wr = (pp[1:0] != 2'd3); end
        else if (pp[1:0] == 2'd2) begin rd = 1; wr = 1; end
        else if (pp[1:0] != 2'd0) rd = 1;
      end
      if (acc == 2'd1) ok = wr;
      else if (acc == 2'd2) ok = rd && !(p1[2] || p1[3]);
      else ok = rd;
      if (ok) begin granted = 1; break; end
    end
    e.idx = ridx; e.nwr = 0; e.waddr = '0; e.pte1 = '0;
    if (incons) e.res = 2'd3;
    else if (!found) e.res = 2'd2;
    else begin
      e.res = granted ? 2'd0 : 2'd1;
      nv = rec; nv[8] = 1'b1;
      if (granted && acc == 2'd1) nv[7] = 1'b1;
      e.pte1 = nv;
      if (nv != rec) begin e.nwr = 1; e.waddr = base + 16*ridx + 8; end
    end
    return e;
  endfunction

  // driver: predict, queue, start, wait for the monitor
  task automatic run(input string name, input int base, input logic [63:0] t, input bit key,
                     input logic [1:0] acc, input bit sec);
    exp_t e;
    e = predict(base, t, key, acc, sec);
    e.wbase = wcnt;
    e.tagname = name;
    sb_q.push_back(e);
    @(negedge clk);
    base_i = base; tag_i = t; key_i = key; acc_i = acc; sec_i = sec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic expect_res(input string req, input logic [1:0] r);
    // a literal cross-check on the verdict of the last run
    chk(res_o == r, req, 64'(res_o), 64'(r));
  endtask

  // monitor: pops and compares on each completion
  always @(negedge clk) begin
    if (!rst && done_o) begin
      n_done++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R12 unexpected done", 64'(res_o), 64'hX);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(res_o == e.res, {e.tagname, " result"}, 64'(res_o), 64'(e.res));
        chk(pte1_o == e.pte1, {e.tagname, " pte1 R9"}, pte1_o, e.pte1);
        if (e.res == 2'd0 || e.res == 2'd1)
          chk(idx_o == e.idx, {e.tagname, " index R6 R7"}, 64'(idx_o), 64'(e.idx));
        chk((wcnt - e.wbase) == e.nwr, {e.tagname, " write count R9"},
            64'(wcnt - e.wbase), 64'(e.nwr));
        if (e.nwr == 1) begin
          chk(lw_addr == e.waddr, {e.tagname, " write addr R1"}, 64'(lw_addr), 64'(e.waddr));
          chk(lw_data == e.pte1, {e.tagname, " write data R9"}, lw_data, e.pte1);
        end
      end
    end
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 60000; c++) @(posedge clk);
    chk(1'b0, "watchdog", 64'(n_done), 64'h0);
    finish_up();
  end

  task automatic prot_case(input string req, input bit key, input logic [2:0] pp,
                           input logic [1:0] acc, input bit nx, input bit g, input logic [1:0] want);
    clear_grp(0);
    put(0, 0, mk0(TAGA, 0, 1), mk1(pp, nx, g, 32'h0000_0A00, 1, 1));
    run(req, 0, TAGA, key, acc, 0);
    expect_res(req, want);
  endtask

  initial begin
    int d0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "reset done low R12", 64'(done_o), 64'h0);
    chk(mem_req_o == 1'b0, "reset no request R11", 64'(mem_req_o), 64'h0);

    // R1 R2 R3 R6: decoys before a grant at entry 3, first use sets R
    clear_grp(0);
    put(0, 1, mk0(TAGA ^ 64'h100, 0, 1), mk1(3'd2, 0, 0, 32'h111, 0, 0));
    put(0, 2, mk0(TAGA, 1, 1), mk1(3'd2, 0, 0, 32'h222, 0, 0));
    put(0, 3, mk0(TAGA, 0, 1), mk1(3'd2, 0, 0, 32'h333, 0, 0));
    put(0, 4, mk0(TAGA, 0, 1), mk1(3'd0, 0, 0, 32'h999, 0, 0));
    run("R1 R6 grant at 3", 0, TAGA, 0, 2'd0, 0);
    expect_res("R6 grant", 2'd0);
    run("R9 referenced already set", 0, TAGA, 0, 2'd0, 0);
    run("R9 write sets changed", 0, TAGA, 0, 2'd1, 0);
    run("R9 no write when flags set", 0, TAGA, 0, 2'd1, 0);
    // R3: tag low bits ignored, bit 7 counts
    run("R3 low tag bits", 0, TAGA | 64'h7F, 0, 2'd0, 0);
    expect_res("R3 low tag bits", 2'd0);
    run("R3 tag bit7", 0, TAGA ^ 64'h80, 0, 2'd0, 0);
    expect_res("R3 tag bit7", 2'd2);

    // R10 empty group, R2 hash id select
    clear_grp(128);
    run("R10 empty group", 128, TAGA, 0, 2'd0, 0);
    expect_res("R10 empty", 2'd2);
    put(128, 0, mk0(TAGA, 1, 1), mk1(3'd2, 0, 0, 32'h444, 0, 0));
    put(128, 6, mk0(TAGA, 0, 0), mk1(3'd2, 0, 0, 32'h444, 0, 0));
    run("R2 wrong hash id", 128, TAGA, 0, 2'd0, 0);
    expect_res("R2 wrong hash id", 2'd2);
    run("R2 secondary match", 128, TAGA, 0, 2'd0, 1);
    expect_res("R2 secondary", 2'd0);

    // R7: two consistent violating matches, last index reported
    clear_grp(256);
    put(256, 1, mk0(TAGA, 0, 1), mk1(3'd3, 0, 0, 32'h555, 0, 0));
    put(256, 5, mk0(TAGA, 0, 1), mk1(3'd3, 0, 0, 32'h555, 1, 1));
    run("R7 last violation", 256, TAGA, 0, 2'd1, 0);
    expect_res("R7 violation", 2'd1);
    chk(idx_o == 3'd5, "R7 last index", 64'(idx_o), 64'd5);

    // R8: inconsistent later match; then R6 grant stops before it
    clear_grp(384);
    put(384, 2, mk0(TAGA, 0, 1), mk1(3'd3, 0, 0, 32'h666, 0, 0));
    put(384, 4, mk0(TAGA, 0, 1), mk1(3'd3, 0, 0, 32'h667, 0, 0));
    run("R8 inconsistent", 384, TAGA, 0, 2'd1, 0);
    expect_res("R8 inconsistent", 2'd3);
    run("R6 early stop", 384, TAGA, 0, 2'd0, 0);
    expect_res("R6 early stop", 2'd0);
    chk(idx_o == 3'd2, "R6 early index", 64'(idx_o), 64'd2);

    // R4 decision table, R5 no-execute
    prot_case("R4 k0 pp3 rd", 0, 3'd3, 2'd0, 0, 0, 2'd0);
    prot_case("R4 k0 pp3 wr", 0, 3'd3, 2'd1, 0, 0, 2'd1);
    prot_case("R4 k0 pp1 wr", 0, 3'd1, 2'd1, 0, 0, 2'd0);
    prot_case("R4 k1 pp0 rd", 1, 3'd0, 2'd0, 0, 0, 2'd1);
    prot_case("R4 k1 pp1 rd", 1, 3'd1, 2'd0, 0, 0, 2'd0);
    prot_case("R4 k1 pp1 wr", 1, 3'd1, 2'd1, 0, 0, 2'd1);
    prot_case("R4 k1 pp2 wr", 1, 3'd2, 2'd1, 0, 0, 2'd0);
    prot_case("R4 k1 pp3 wr", 1, 3'd3, 2'd1, 0, 0, 2'd1);
    prot_case("R4 high code", 0, 3'd4, 2'd0, 0, 0, 2'd1);
    prot_case("R4 fetch k1 pp0", 1, 3'd0, 2'd2, 0, 0, 2'd1);
    prot_case("R5 fetch ok", 0, 3'd2, 2'd2, 0, 0, 2'd0);
    prot_case("R5 fetch nx bit2", 0, 3'd2, 2'd2, 1, 0, 2'd1);
    prot_case("R5 fetch nx bit3", 0, 3'd2, 2'd2, 0, 1, 2'd1);

    // R12: start while busy has no effect
    d0 = n_done;
    begin
      exp_t e;
      e = predict(256, TAGA, 0, 2'd0, 0);
      e.wbase = wcnt;
      e.tagname = "R12 busy start";
      sb_q.push_back(e);
      @(negedge clk);
      base_i = 256; tag_i = TAGA; key_i = 0; acc_i = 2'd0; sec_i = 0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      base_i = 0; sec_i = 1; acc_i = 2'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (sb_q.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
    end
    chk(n_done == d0 + 1, "R12 one done per search", 64'(n_done - d0), 64'd1);

    finish_up();
  end
endmodule